// File: doc/BRIEF.md
# Bit-Serial Compare-Exchange Routing Node

This block is a two-input, two-output self-routing element for a bit-serial sorting network. Two words enter one bit per clock, most significant bit first, on serial inputs `in_a` and `in_b`. While the streams agree bit for bit, the node passes `in_a` to the upper output and `in_b` to the lower output. This setting is called bypass.

At the first valid bit where the streams differ, the node compares the two bits and picks exchange or bypass, so that the larger word leaves on one chosen port and the smaller word on the other. The choice steers that same bit with no delay. A latch then stores the choice and holds it for the rest of the word. The choice stays in force until a synchronous `word_clr` marks the word boundary and frees the node for the next pair.

A direction input chooses whether the larger word leaves on the upper or the lower port. This lets one node serve as either an ascending or a descending comparator in a bitonic stage. Bits presented with `bit_vld` low take no part in the decision.

Top module: `cxn_node`

## Requirements
- R1: After `rst_n` is asserted (asynchronous, active low), `decided` is 0 and the node is in bypass: `out_up` equals `in_a` and `out_dn` equals `in_b`.
- R2: While undecided, and the current bit is not both valid and differing, the outputs are in bypass.
- R3: On the first valid bit where `in_a` differs from `in_b` while undecided, that same bit is already routed: the 1 goes to the maximum port and the 0 to the other. `decided` rises on the next cycle, unless `word_clr` is high in that same cycle.
- R4: Once decided, the routing setting is held for all later bits until `word_clr`. The two outputs are always a permutation of the two inputs.
- R5: `max_low` = 0 sends the larger word to `out_up`; `max_low` = 1 sends it to `out_dn`. The node samples `max_low` only on the deciding bit. Changing it after the decision has no effect until the next word.
- R6: If both words are identical, the node stays in bypass for the whole word and `decided` never rises.
- R7: `word_clr` is synchronous and applies at the clock edge. On the following cycle the node is undecided and in bypass. It takes priority over a difference seen in the same cycle, although that cycle's bit is still routed by the comparison.
- R8: A differing bit with `bit_vld` low neither sets the decision nor changes the routing of the outputs.
- R9: `decided` is high from the cycle after the deciding bit until the cycle after `word_clr`. Over a whole word, the maximum port carries the larger word and the other port carries the smaller.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_a | input | 1 | Serial input A, MSB first |
| in_b | input | 1 | Serial input B, MSB first |
| bit_vld | input | 1 | Current bits are valid for comparison |
| max_low | input | 1 | 0: larger word to `out_up`; 1: larger word to `out_dn` |
| word_clr | input | 1 | Synchronous word-boundary clear of the decision |
| out_up | output | 1 | Upper serial output |
| out_dn | output | 1 | Lower serial output |
| decided | output | 1 | Routing decision latched |

## Verification
The bench checks the deciding bit itself. A design that steers only from the latched state would send that bit to the wrong port, and its words would be wrong in exactly one bit position. It moves `max_low` after the decision and presents differing bits with `bit_vld` low. A design that reads the direction live, or that compares invalid bits, would flip or latch the routing in those cycles. It also sends identical words and raises `word_clr` in the same cycle as a first difference. A design with the wrong priority would come out of the clear already decided and carry a stale setting into the next word.

// File: rtl/cxn_pkg.sv
package cxn_pkg;

  typedef enum logic {
    ROUTE_PASS = 1'b0,
    ROUTE_SWAP = 1'b1
  } route_e;

  typedef struct packed {
    logic   decided;
    route_e route;
  } cxn_state_t;

endpackage

// File: rtl/cxn_detect.sv
module cxn_detect
  import cxn_pkg::*;
(
  input  logic   in_a,
  input  logic   in_b,
  input  logic   bit_vld,
  input  logic   max_low,
  output logic   differ,
  output route_e route_now
);

  // The bit that is 1 belongs to the larger word.
  // Swap when that word would otherwise land on the wrong port.
  always_comb begin
    differ    = bit_vld & (in_a ^ in_b);
    route_now = ROUTE_PASS;
    if (differ) begin
      route_now = route_e'(max_low ? in_a : in_b);
    end
  end

endmodule

// File: rtl/cxn_state.sv
module cxn_state
  import cxn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       word_clr,
  input  logic       differ,
  input  route_e     route_now,
  output cxn_state_t state_q
);

  cxn_state_t state_d;
  logic       ld_en;

  always_comb begin
    ld_en   = 1'b0;
    state_d = state_q;
    if (word_clr) begin
      ld_en           = 1'b1;
      state_d.decided = 1'b0;
      state_d.route   = ROUTE_PASS;
    end else if (!state_q.decided && differ) begin
      ld_en           = 1'b1;
      state_d.decided = 1'b1;
      state_d.route   = route_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q.decided <= 1'b0;
      state_q.route   <= ROUTE_PASS;
    end else if (ld_en) begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/cxn_steer.sv
module cxn_steer
  import cxn_pkg::*;
(
  input  route_e sel,
  input  logic   in_a,
  input  logic   in_b,
  output logic   out_up,
  output logic   out_dn
);

  always_comb begin
    if (sel == ROUTE_SWAP) begin
      out_up = in_b;
      out_dn = in_a;
    end else begin
      out_up = in_a;
      out_dn = in_b;
    end
  end

endmodule

// File: rtl/cxn_node.sv
module cxn_node
  import cxn_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_a,
  input  logic in_b,
  input  logic bit_vld,
  input  logic max_low,
  input  logic word_clr,
  output logic out_up,
  output logic out_dn,
  output logic decided
);

  logic       differ;
  route_e     route_now;
  route_e     route_eff;
  cxn_state_t state_q;

  cxn_detect u_detect (
    .in_a      (in_a),
    .in_b      (in_b),
    .bit_vld   (bit_vld),
    .max_low   (max_low),
    .differ    (differ),
    .route_now (route_now)
  );

  cxn_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_clr  (word_clr),
    .differ    (differ),
    .route_now (route_now),
    .state_q   (state_q)
  );

  // The latched setting wins; before the decision, the live comparison steers.
  always_comb begin
    route_eff = state_q.decided ? state_q.route : route_now;
  end

  cxn_steer u_steer (
    .sel    (route_eff),
    .in_a   (in_a),
    .in_b   (in_b),
    .out_up (out_up),
    .out_dn (out_dn)
  );

  assign decided = state_q.decided;

endmodule

// File: rtl/cxn_node_chk.sv
module cxn_node_chk (
  input logic clk,
  input logic rst_n,
  input logic in_a,
  input logic in_b,
  input logic bit_vld,
  input logic max_low,
  input logic word_clr,
  input logic out_up,
  input logic out_dn,
  input logic decided
);

  p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!decided && !(bit_vld && (in_a != in_b))) |-> (out_up == in_a && out_dn == in_b));

  p_first_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!decided && bit_vld && (in_a != in_b)) |->
      (max_low ? (out_dn && !out_up) : (out_up && !out_dn)));

  p_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!decided && bit_vld && (in_a != in_b) && !word_clr) |=> decided);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (decided && !word_clr) |=> decided);

  p_permute_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({out_up, out_dn}) == $countones({in_a, in_b}));

  p_stay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!decided && !word_clr && !(bit_vld && (in_a != in_b))) |=> !decided);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    word_clr |=> !decided);

endmodule

bind cxn_node cxn_node_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_a     (in_a),
  .in_b     (in_b),
  .bit_vld  (bit_vld),
  .max_low  (max_low),
  .word_clr (word_clr),
  .out_up   (out_up),
  .out_dn   (out_dn),
  .decided  (decided)
);

// File: tb/tb_cxn_node.sv
`timescale 1ns/1ps
module tb_cxn_node;

  logic clk, rst_n, in_a, in_b, bit_vld, max_low, word_clr;
  logic out_up, out_dn, decided;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // Reference state: 0 none, 1 A larger, 2 B larger
  int   ref_big = 0;
  logic ref_low = 0;
  logic cap_up, cap_dn;

  cxn_node dut (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .bit_vld(bit_vld),
    .max_low(max_low), .word_clr(word_clr), .out_up(out_up), .out_dn(out_dn),
    .decided(decided)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic a, input logic b, input logic v,
                      input logic d, input logic c, input string req);
    int   big_now;
    logic low_now, e_up, e_dn, mx, mn;
    @(negedge clk);
    in_a = a; in_b = b; bit_vld = v; max_low = d; word_clr = c;
    #1;
    big_now = ref_big;
    low_now = ref_low;
    if (ref_big == 0 && v && a != b) begin
      big_now = a ? 1 : 2;
      low_now = d;
    end
    if (big_now == 0) begin
      e_up = a; e_dn = b;
    end else begin
      mx = (big_now == 1) ? a : b;
      mn = (big_now == 1) ? b : a;
      e_up = low_now ? mn : mx;
      e_dn = low_now ? mx : mn;
    end
    check(out_up == e_up && out_dn == e_dn, req, "outputs {up,dn}",
          {out_up, out_dn}, {e_up, e_dn});
    check(decided == (ref_big != 0), req, "decided", decided, ref_big != 0);
    cap_up = out_up;
    cap_dn = out_dn;
    @(posedge clk);
    if (c) ref_big = 0;
    else if (ref_big == 0 && v && a != b) begin
      ref_big = a ? 1 : 2;
      ref_low = d;
    end
  endtask

  // Whole word, MSB first, clear on the last bit
  task automatic send_word(input logic [7:0] wa, input logic [7:0] wb,
                           input logic d, input string req);
    logic [7:0] up_w, dn_w, mx, mn;
    for (int i = 7; i >= 0; i--) begin
      step(wa[i], wb[i], 1'b1, d, i == 0, req);
      up_w[i] = cap_up;
      dn_w[i] = cap_dn;
    end
    mx = (wa > wb) ? wa : wb;
    mn = (wa > wb) ? wb : wa;
    check(up_w == (d ? mn : mx), "R9", "upper word", up_w, d ? mn : mx);
    check(dn_w == (d ? mx : mn), "R9", "lower word", dn_w, d ? mx : mn);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_a = 1; in_b = 0; bit_vld = 0; max_low = 0; word_clr = 0;
    #5;
    check(decided == 0, "R1", "decided in reset", decided, 0);
    check(out_up == 1 && out_dn == 0, "R1", "bypass in reset", {out_up, out_dn}, 2);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;

    step(1, 0, 0, 0, 0, "R8");             // invalid differing bit ignored
    step(0, 1, 0, 0, 0, "R8");
    step(1, 1, 1, 0, 0, "R2");
    step(0, 0, 1, 0, 1, "R7");

    send_word(8'hA5, 8'h3C, 0, "R3");
    send_word(8'h3C, 8'hA5, 0, "R3");
    send_word(8'h5A, 8'h5A, 0, "R6");
    send_word(8'h81, 8'h80, 1, "R5");
    send_word(8'h40, 8'hC0, 1, "R5");
    send_word(8'h00, 8'hFF, 0, "R4");

    // Direction change after the decision has no effect (R5)
    step(0, 1, 1, 0, 0, "R5");
    step(1, 0, 1, 1, 0, "R5");
    step(1, 0, 1, 1, 0, "R4");
    step(0, 0, 1, 1, 1, "R7");

    // Clear coincides with the first difference (R7)
    step(1, 0, 1, 0, 1, "R7");
    step(0, 1, 1, 1, 0, "R7");
    step(1, 0, 1, 0, 0, "R4");
    step(0, 0, 0, 0, 1, "R7");

    // Asynchronous reset mid-word (R1)
    step(0, 1, 1, 0, 0, "R3");
    @(negedge clk); rst_n = 0; in_a = 1; in_b = 0; bit_vld = 0; #1;
    check(decided == 0 && out_up == 1 && out_dn == 0, "R1", "after async reset",
          {decided, out_up, out_dn}, 2);
    ref_big = 0;
    @(negedge clk); rst_n = 1;
    step(1, 1, 1, 0, 0, "R2");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule